// File: doc/BRIEF.md
# Track Processor Readout Block Builder

For each bunch crossing chosen for readout, this block produces the track-processor part of the event record. The record is a stream of 16-bit words, one word per clock. The parent packer pulses `start` with the crossing's data on the inputs. The block captures that data and then emits a variable-length block. The block always opens with the modified sync-error word, followed by a summary word. After these come the barrel muon stubs, the three output tracks and at most one lookup-table output frame. Which of these appear is decided by the configuration bits and by the data itself.

Barrel stubs appear only when barrel readout is enabled. Zero suppression removes barrel stubs whose quality is zero and tracks whose mode is zero. A spy select picks at most one track whose lookup output is appended as a fourth frame. The block marks its final word with `out_done`. The packer may start the next crossing in that same cycle, which gives gapless back-to-back blocks.

Top module: `tpb_block_builder`

## Requirements
- R1: An accepted block always begins with two words. The first is the captured sync-error input with bit 15 cleared. The second is the summary word.
- R2: The summary word carries the mode of track t (t = 0..2) in bits 3t+2:3t. Bit 9 is 1 when barrel stub A has nonzero quality, and bit 10 is 1 when stub D has nonzero quality. Bits 15:11 are 0.
- R3: When the barrel-enable input is 0, no barrel stub frame is emitted, whatever the qualities are.
- R4: With zero suppression 0, all three tracks (three frames each) are emitted. Both barrel stubs (two frames each) are also emitted when barrel readout is enabled.
- R5: With zero suppression 1, a barrel stub is emitted only if its quality is nonzero, and a track only if its mode is nonzero.
- R6: Spy select 0 appends no lookup frame. A spy select of 1, 2 or 3 appends the lookup frame of track 1, 2 or 3 directly after that track's third frame, and only if that track is emitted.
- R7: The order of the words is: sync word, summary, stub A frames 1-2, stub D frames 1-2, then track 1, track 2 and track 3. Each track gives frames 1-3 and then its optional lookup frame.
- R8: Bit 15 of every emitted word is 0, even when the corresponding input word has bit 15 set.
- R9: A block holds 2 to 16 words on consecutive cycles with `out_valid` high. `out_done` is high on the last word only. With no new start, `out_valid` is low in the following cycle.
- R10: `start` is accepted when the block is idle or in the cycle where `out_done` is high. The block samples its inputs in that cycle. A `start` in any other busy cycle is ignored and leaves the block in progress unchanged.
- R11: After reset, `out_valid` and `out_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block for the crossing presented on the data inputs |
| sync_err | input | 16 | Modified sync-error word |
| bar_qual | input | 6 | Barrel stub qualities, stub A in bits 2:0, stub D in bits 5:3 |
| bar_frames | input | 64 | Barrel frames, stub b frame f at bits 16(2b+f)+15:16(2b+f) |
| trk_mode | input | 9 | Track modes, track t at bits 3t+2:3t |
| trk_frames | input | 144 | Track frames, track t frame f at bits 16(3t+f)+15:16(3t+f) |
| trk_lut | input | 48 | Lookup output frame of track t at bits 16t+15:16t |
| cfg_bar_en | input | 1 | Barrel readout enable |
| cfg_zs | input | 1 | Zero suppression enable |
| cfg_spy | input | 2 | Lookup spy select (0 none, 1..3 track) |
| out_valid | output | 1 | Output word valid |
| out_word | output | 16 | Output data word |
| out_done | output | 1 | Last word of the block |

## Verification
Two events can fall in the same cycle: the final word of one block with `out_done` high, and the acceptance of the next `start`. The bench provokes this by raising `start` with fresh crossing data exactly on the cycle where `out_done` is seen. It then compares the second block word by word against a model built from the new data. A correct result needs the last word of the first block intact, no idle cycle between the blocks, and a second block that carries only the new inputs. As a counter-case, a `start` raised in the middle of a block must leave that block's remaining words unchanged.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  typedef enum logic [2:0] {
    SK_SYNC    = 3'd0,
    SK_SUMMARY = 3'd1,
    SK_BAR     = 3'd2,
    SK_TRK     = 3'd3,
    SK_LUT     = 3'd4
  } slot_kind_e;

  localparam int BAR_FRAMES = 2;
  localparam int TRK_FRAMES = 3;
  localparam int TRK_SLOTS  = TRK_FRAMES + 1;

  // Slot layout: 0 sync, 1 summary, barrel frames, then per track 3 frames + lookup
  function automatic slot_kind_e slot_kind(input int s, input int nbar);
    int r;
    if (s == 0) return SK_SYNC;
    if (s == 1) return SK_SUMMARY;
    if (s < 2 + BAR_FRAMES * nbar) return SK_BAR;
    r = s - 2 - BAR_FRAMES * nbar;
    if ((r % TRK_SLOTS) == TRK_FRAMES) return SK_LUT;
    return SK_TRK;
  endfunction

  function automatic int slot_unit(input int s, input int nbar);
    if (s < 2) return 0;
    if (s < 2 + BAR_FRAMES * nbar) return (s - 2) / BAR_FRAMES;
    return (s - 2 - BAR_FRAMES * nbar) / TRK_SLOTS;
  endfunction

  function automatic int slot_frame(input int s, input int nbar);
    if (s < 2) return 0;
    if (s < 2 + BAR_FRAMES * nbar) return (s - 2) % BAR_FRAMES;
    return (s - 2 - BAR_FRAMES * nbar) % TRK_SLOTS;
  endfunction

endpackage

// File: rtl/tpb_slot_mask.sv
module tpb_slot_mask
  import tpb_pkg::*;
#(
  parameter int N_BAR  = 2,
  parameter int N_TRK  = 3,
  parameter int QUAL_W = 3,
  parameter int MODE_W = 3,
  parameter int SPY_W  = 2,
  parameter int NSLOT  = 18
) (
  input  logic [N_BAR*QUAL_W-1:0] qual,
  input  logic [N_TRK*MODE_W-1:0] mode,
  input  logic                    bar_en,
  input  logic                    zs,
  input  logic [SPY_W-1:0]        spy,
  output logic [NSLOT-1:0]        mask,
  output logic [N_TRK-1:0]        lut_keep
);

  logic [N_BAR-1:0] bar_keep;
  logic [N_TRK-1:0] trk_keep;

  for (genvar b = 0; b < N_BAR; b++) begin : g_bar
    assign bar_keep[b] = bar_en & (~zs | (|qual[b*QUAL_W +: QUAL_W]));
  end

  for (genvar t = 0; t < N_TRK; t++) begin : g_trk
    assign trk_keep[t] = ~zs | (|mode[t*MODE_W +: MODE_W]);
    assign lut_keep[t] = trk_keep[t] & (spy == SPY_W'(t + 1));
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam slot_kind_e K = slot_kind(s, N_BAR);
    localparam int         U = slot_unit(s, N_BAR);
    if (K == SK_SYNC || K == SK_SUMMARY) begin : g_fixed
      assign mask[s] = 1'b1;
    end else if (K == SK_BAR) begin : g_b
      assign mask[s] = bar_keep[U];
    end else if (K == SK_TRK) begin : g_t
      assign mask[s] = trk_keep[U];
    end else begin : g_l
      assign mask[s] = lut_keep[U];
    end
  end

endmodule

// File: rtl/tpb_next_slot.sv
module tpb_next_slot #(
  parameter int NSLOT  = 18,
  parameter int SLOT_W = 5
) (
  input  logic [NSLOT-1:0]  mask,
  input  logic [SLOT_W-1:0] cur,
  output logic [SLOT_W-1:0] nxt,
  output logic              last
);

  always_comb begin
    nxt  = cur;
    last = 1'b1;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (mask[s] && (s > int'(cur))) begin
        nxt  = SLOT_W'(s);
        last = 1'b0;
      end
    end
  end

endmodule

// File: rtl/tpb_word_mux.sv
module tpb_word_mux
  import tpb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int N_BAR  = 2,
  parameter int N_TRK  = 3,
  parameter int QUAL_W = 3,
  parameter int MODE_W = 3,
  parameter int SLOT_W = 5
) (
  input  logic [SLOT_W-1:0]                    cur,
  input  logic [WORD_W-1:0]                    sync,
  input  logic [N_BAR*QUAL_W-1:0]              qual,
  input  logic [N_TRK*MODE_W-1:0]              mode,
  input  logic [N_BAR*BAR_FRAMES*WORD_W-1:0]   bar_fr,
  input  logic [N_TRK*TRK_FRAMES*WORD_W-1:0]   trk_fr,
  input  logic [N_TRK*WORD_W-1:0]              lut_fr,
  output logic [WORD_W-1:0]                    word
);

  logic [WORD_W-1:0] summary;

  always_comb begin
    summary = '0;
    summary[N_TRK*MODE_W-1:0] = mode;
    for (int b = 0; b < N_BAR; b++)
      summary[N_TRK*MODE_W + b] = |qual[b*QUAL_W +: QUAL_W];
  end

  always_comb begin
    int u;
    int f;
    u = slot_unit(int'(cur), N_BAR);
    f = slot_frame(int'(cur), N_BAR);
    word = '0;
    case (slot_kind(int'(cur), N_BAR))
      SK_SYNC:    word = sync;
      SK_SUMMARY: word = summary;
      SK_BAR:     word = bar_fr[(u*BAR_FRAMES + f)*WORD_W +: WORD_W];
      SK_TRK:     word = trk_fr[(u*TRK_FRAMES + f)*WORD_W +: WORD_W];
      SK_LUT:     word = lut_fr[u*WORD_W +: WORD_W];
      default:    word = '0;
    endcase
    word[WORD_W-1] = 1'b0;
  end

endmodule

// File: rtl/tpb_block_builder.sv
module tpb_block_builder
  import tpb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int N_BAR  = 2,
  parameter int N_TRK  = 3,
  parameter int QUAL_W = 3,
  parameter int MODE_W = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [WORD_W-1:0]                    sync_err,
  input  logic [N_BAR*QUAL_W-1:0]              bar_qual,
  input  logic [N_BAR*2*WORD_W-1:0]            bar_frames,
  input  logic [N_TRK*MODE_W-1:0]              trk_mode,
  input  logic [N_TRK*3*WORD_W-1:0]            trk_frames,
  input  logic [N_TRK*WORD_W-1:0]              trk_lut,
  input  logic                                 cfg_bar_en,
  input  logic                                 cfg_zs,
  input  logic [$clog2(N_TRK+1)-1:0]           cfg_spy,
  output logic                                 out_valid,
  output logic [WORD_W-1:0]                    out_word,
  output logic                                 out_done
);

  localparam int NSLOT     = 2 + N_BAR*BAR_FRAMES + N_TRK*TRK_SLOTS;
  localparam int SLOT_W    = $clog2(NSLOT);
  localparam int SPY_W     = $clog2(N_TRK+1);
  localparam int MAX_WORDS = 2 + N_BAR*BAR_FRAMES + N_TRK*TRK_FRAMES + 1;
  localparam int CNT_W     = $clog2(MAX_WORDS+1);

  // Captured crossing
  logic [WORD_W-1:0]                  snap_sync;
  logic [N_BAR*QUAL_W-1:0]            snap_qual;
  logic [N_BAR*2*WORD_W-1:0]          snap_bar;
  logic [N_TRK*MODE_W-1:0]            snap_mode;
  logic [N_TRK*3*WORD_W-1:0]          snap_trk;
  logic [N_TRK*WORD_W-1:0]            snap_lut;
  logic                               snap_bar_en;
  logic                               snap_zs;
  logic [SPY_W-1:0]                   snap_spy;

  logic               busy;
  logic [SLOT_W-1:0]  cur_slot;
  logic [SLOT_W-1:0]  nxt_slot;
  logic               last_slot;
  logic [NSLOT-1:0]   slot_mask;
  logic [N_TRK-1:0]   lut_keep;
  logic [CNT_W-1:0]   word_cnt;

  // Named events
  logic start_acc;
  logic start_ign;
  assign start_acc = start & (~busy | last_slot);
  assign start_ign = start & busy & ~last_slot;

  tpb_slot_mask #(
    .N_BAR(N_BAR), .N_TRK(N_TRK), .QUAL_W(QUAL_W), .MODE_W(MODE_W),
    .SPY_W(SPY_W), .NSLOT(NSLOT)
  ) u_mask (
    .qual(snap_qual), .mode(snap_mode), .bar_en(snap_bar_en), .zs(snap_zs),
    .spy(snap_spy), .mask(slot_mask), .lut_keep(lut_keep)
  );

  tpb_next_slot #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_next (
    .mask(slot_mask), .cur(cur_slot), .nxt(nxt_slot), .last(last_slot)
  );

  tpb_word_mux #(
    .WORD_W(WORD_W), .N_BAR(N_BAR), .N_TRK(N_TRK), .QUAL_W(QUAL_W),
    .MODE_W(MODE_W), .SLOT_W(SLOT_W)
  ) u_mux (
    .cur(cur_slot), .sync(snap_sync), .qual(snap_qual), .mode(snap_mode),
    .bar_fr(snap_bar), .trk_fr(snap_trk), .lut_fr(snap_lut), .word(out_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_sync   <= '0;
      snap_qual   <= '0;
      snap_bar    <= '0;
      snap_mode   <= '0;
      snap_trk    <= '0;
      snap_lut    <= '0;
      snap_bar_en <= 1'b0;
      snap_zs     <= 1'b0;
      snap_spy    <= '0;
    end else if (start_acc) begin
      snap_sync   <= sync_err;
      snap_qual   <= bar_qual;
      snap_bar    <= bar_frames;
      snap_mode   <= trk_mode;
      snap_trk    <= trk_frames;
      snap_lut    <= trk_lut;
      snap_bar_en <= cfg_bar_en;
      snap_zs     <= cfg_zs;
      snap_spy    <= cfg_spy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_slot <= '0;
      word_cnt <= '0;
    end else if (start_acc) begin
      busy     <= 1'b1;
      cur_slot <= '0;
      word_cnt <= CNT_W'(1);
    end else if (busy) begin
      if (last_slot) begin
        busy <= 1'b0;
      end else begin
        cur_slot <= nxt_slot;
        word_cnt <= word_cnt + 1'b1;
      end
    end
  end

  assign out_valid = busy;
  assign out_done  = busy & last_slot;

  AST_FIRST_IS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> out_valid && out_word == {1'b0, $past(sync_err[WORD_W-2:0])}); // R1
  AST_SUMMARY_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> ##1 out_valid && out_word[N_TRK*MODE_W-1:0] == $past(trk_mode, 2)); // R2
  AST_BARREL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && slot_kind(int'(cur_slot), N_BAR) == SK_BAR |-> snap_bar_en); // R3
  AST_ONE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lut_keep) <= 1); // R6
  AST_SLOT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_done && !start_acc |=> out_valid && cur_slot > $past(cur_slot)); // R7
  AST_WORD_MSB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_word[WORD_W-1]); // R8
  AST_LENGTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> word_cnt >= CNT_W'(2) && word_cnt <= CNT_W'(MAX_WORDS)); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done && !start |=> !out_valid); // R9
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_ign |=> $stable(snap_sync) && $stable(snap_mode) && out_valid); // R10

endmodule

// File: tb/tpb_block_builder_tb.sv
module tpb_block_builder_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [15:0]  sync_err = '0;
  logic [5:0]   bar_qual = '0;
  logic [63:0]  bar_frames = '0;
  logic [8:0]   trk_mode = '0;
  logic [143:0] trk_frames = '0;
  logic [47:0]  trk_lut = '0;
  logic         cfg_bar_en = 1'b0;
  logic         cfg_zs = 1'b0;
  logic [1:0]   cfg_spy = '0;
  logic         out_valid;
  logic [15:0]  out_word;
  logic         out_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [15:0] exp_q [0:19];
  int exp_n;

  always #10 clk = ~clk;

  tpb_block_builder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sync_err(sync_err),
    .bar_qual(bar_qual), .bar_frames(bar_frames), .trk_mode(trk_mode),
    .trk_frames(trk_frames), .trk_lut(trk_lut), .cfg_bar_en(cfg_bar_en),
    .cfg_zs(cfg_zs), .cfg_spy(cfg_spy), .out_valid(out_valid),
    .out_word(out_word), .out_done(out_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Distinct data with bit 15 set everywhere (R8 must clear it)
  task automatic fill(input logic [3:0] seed);
    sync_err = 16'h8000 | {4'h0, seed, 8'h5A};
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 2; f++)
        bar_frames[(b*2+f)*16 +: 16] = {4'hA, seed, 4'(b), 4'(f)};
    for (int t = 0; t < 3; t++) begin
      for (int f = 0; f < 3; f++)
        trk_frames[(t*3+f)*16 +: 16] = {4'hC, seed, 4'(t), 4'(f)};
      trk_lut[t*16 +: 16] = {4'hE, seed, 4'(t), 4'hF};
    end
  endtask

  task automatic push(input logic [15:0] w);
    exp_q[exp_n] = {1'b0, w[14:0]};
    exp_n++;
  endtask

  task automatic build_exp();
    logic [15:0] s;
    exp_n = 0;
    push(sync_err);
    s = 16'h0;
    s[8:0] = trk_mode;
    s[9]  = (bar_qual[2:0] != 0);
    s[10] = (bar_qual[5:3] != 0);
    push(s);
    for (int b = 0; b < 2; b++)
      if (cfg_bar_en && (!cfg_zs || bar_qual[b*3 +: 3] != 0))
        for (int f = 0; f < 2; f++) push(bar_frames[(b*2+f)*16 +: 16]);
    for (int t = 0; t < 3; t++)
      if (!cfg_zs || trk_mode[t*3 +: 3] != 0) begin
        for (int f = 0; f < 3; f++) push(trk_frames[(t*3+f)*16 +: 16]);
        if (int'(cfg_spy) == t + 1) push(trk_lut[t*16 +: 16]);
      end
  endtask

  // Called at the negedge where the first word is visible; returns at the done negedge
  task automatic collect(input string req, input int inject_at);
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      chk(out_valid === 1'b1, req, 32'(out_valid), 32'h1);
      chk(out_word === exp_q[i], req, 32'(out_word), 32'(exp_q[i]));
      if (out_done === 1'b1) begin
        seen = 1;
        chk(i + 1 == exp_n, {req, " length"}, 32'(i + 1), 32'(exp_n));
      end else begin
        start = (i == inject_at);
        if (i == inject_at) begin
          sync_err = 16'h1234; trk_mode = 9'h0; cfg_zs = 1'b1; cfg_spy = 2'd0;
        end
        @(negedge clk);
      end
    end
    if (!seen) chk(1'b0, {req, " no done"}, 32'h0, 32'h1);
  endtask

  task automatic run_block(input string req);
    build_exp();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    collect(req, -1);
    start = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 idle after done", 32'(out_valid), 32'h0);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R11 valid", 32'(out_valid), 32'h0);
    chk(out_done === 1'b0, "R11 done", 32'(out_done), 32'h0);
  endtask

  task automatic t_zs_off_all();
    fill(4'h1); cfg_zs = 0; cfg_bar_en = 1; cfg_spy = 0; bar_qual = 0; trk_mode = 0;
    run_block("R4 R1 R2 R8 zs off");
    chk(exp_n == 15, "R4 count", 32'(exp_n), 32'd15);
  endtask

  task automatic t_zs_on_mixed();
    fill(4'h2); cfg_zs = 1; cfg_bar_en = 1; cfg_spy = 3;
    bar_qual = {3'd5, 3'd0}; trk_mode = {3'd7, 3'd0, 3'd3};
    run_block("R5 R6 R7 zs on");
  endtask

  task automatic t_bar_off();
    fill(4'h3); cfg_zs = 0; cfg_bar_en = 0; cfg_spy = 0;
    bar_qual = {3'd2, 3'd6}; trk_mode = {3'd1, 3'd2, 3'd4};
    run_block("R3 barrel off");
  endtask

  task automatic t_spy_sweep();
    for (int s = 0; s < 4; s++) begin
      fill(4'(4 + s)); cfg_zs = 0; cfg_bar_en = 1; cfg_spy = 2'(s);
      bar_qual = 6'o31; trk_mode = 9'o123;
      run_block("R6 R7 spy sweep");
    end
  endtask

  task automatic t_spy_suppressed();
    fill(4'h8); cfg_zs = 1; cfg_bar_en = 1; cfg_spy = 2;
    bar_qual = 6'o10; trk_mode = {3'd2, 3'd0, 3'd6};
    run_block("R6 spy on suppressed track");
  endtask

  task automatic t_min();
    fill(4'h9); cfg_zs = 1; cfg_bar_en = 1; cfg_spy = 1; bar_qual = 0; trk_mode = 0;
    run_block("R9 minimum");
    chk(exp_n == 2, "R9 min count", 32'(exp_n), 32'd2);
  endtask

  task automatic t_max();
    fill(4'hA); cfg_zs = 0; cfg_bar_en = 1; cfg_spy = 1; bar_qual = 6'o77; trk_mode = 9'o777;
    run_block("R9 maximum");
    chk(exp_n == 16, "R9 max count", 32'(exp_n), 32'd16);
  endtask

  task automatic t_ignore_start();
    fill(4'hB); cfg_zs = 0; cfg_bar_en = 1; cfg_spy = 2; bar_qual = 6'o12; trk_mode = 9'o246;
    build_exp();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    collect("R10 mid-block start ignored", 1);
    start = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 no restart", 32'(out_valid), 32'h0);
  endtask

  task automatic t_back_to_back();
    fill(4'hC); cfg_zs = 1; cfg_bar_en = 1; cfg_spy = 1; bar_qual = 6'o40; trk_mode = 9'o005;
    build_exp();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    collect("R10 first block", -1);
    fill(4'hD); cfg_zs = 0; cfg_bar_en = 0; cfg_spy = 3; bar_qual = 6'o11; trk_mode = 9'o700;
    build_exp();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    collect("R10 start on done", -1);
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 idle after second", 32'(out_valid), 32'h0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zs_off_all();
    t_zs_on_mixed();
    t_bar_off();
    t_spy_sweep();
    t_spy_suppressed();
    t_min();
    t_max();
    t_ignore_start();
    t_back_to_back();
    repeat (2) @(negedge clk);
    report();
  end

endmodule